// File: doc/BRIEF.md
# Multi-Locality Ownership Arbiter

This block decides which of five localities (0 to 4) currently owns a shared command interface of a security module. A bus host reaches each locality through its own 4 KiB register window, and the address bits above the window select the locality. At offset zero of every window sits a one-byte access register. Through it a locality can ask for ownership, give ownership up, take ownership away from a lower-numbered owner, and acknowledge that it lost ownership that way.

Ownership moves in three ways. An idle interface is granted at once to the first requester. When the owner releases, ownership goes to the highest-numbered locality with a request outstanding. A higher-numbered locality can seize ownership. The loser of a seize keeps its request outstanding and is marked as seized. If the command engine reports that a command is executing when ownership must move, the block raises a cancel request. It switches the owner only when the engine answers that the abort has completed.

The block reports the current owner and gives a one-cycle locality-changed pulse, which the interrupt logic consumes. Locality 4 accepts writes only from accesses flagged as coming from hardware.

Top module: `lty_owner_arb`

## Requirements
- R1: After reset, no locality owns the interface, `cancel_req` is low, and every locality's access register reads 0x80 when `established` is high.
- R2: Access register read layout: bit 7 always 1, bit 5 = this locality owns, bit 4 = been-seized, bit 2 = some other locality has a request outstanding, bit 1 = own request outstanding, bit 0 = inverse of `established`. Bits 6 and 3 read 0, so a pending seize is never visible. A valid locality at any offset other than 0 reads 0x00.
- R3: Writing bit 1 (request) grants ownership at once when no locality owns. Otherwise it sets that locality's request flag. The owner's own request write has no effect.
- R4: The owner writing bit 5 releases ownership to the highest-numbered locality with a request outstanding, or to nobody if there is none. The old owner loses both its owner and request flags.
- R5: A non-owner writing bit 5 clears only its own request flag.
- R6: A seize (bit 3) is accepted only if no locality owns or the writer's number is above the owner's. It is refused while the writer already has a seize pending, or while a higher locality has one pending. A write that carries bit 3 ignores bits 5 and 1.
- R7: On a seize handover, the old owner gains been-seized and keeps its request flag. Writing 1 to bit 4 clears been-seized.
- R8: Whenever ownership changes to a locality, `loc_changed` pulses for exactly one cycle with `loc_changed_id` equal to the new owner. The new owner's request and seize flags are cleared.
- R9: Writes to locality 4 with `bus_from_hw` low are ignored. With `bus_from_hw` high they take effect.
- R10: If `cmd_executing` is high when a release or seize would move ownership, `cancel_req` rises and the owner is held until `abort_done`. Meanwhile a newly started handover only retargets the pending one, and direct ownership changes are dropped. Writes in the completion cycle are ignored.
- R11: Locality field values 5 to 7 read 0x00, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_from_hw | input | 1 | Access originates from the hardware-only path |
| bus_addr | input | WIN_BITS+3 | Locality in top 3 bits, window offset below |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| established | input | 1 | Establishment state; reported inverted in bit 0 |
| cmd_executing | input | 1 | Command engine is executing a command |
| abort_done | input | 1 | Command engine finished the requested abort |
| cancel_req | output | 1 | Abort requested; held until `abort_done` |
| owner_valid | output | 1 | Some locality owns the interface |
| owner_id | output | 3 | Owning locality |
| loc_changed | output | 1 | One-cycle ownership-change pulse |
| loc_changed_id | output | 3 | New owner for the pulse |

## Verification
The hardest state to reach is a seize that is refused because a higher locality already has a seize pending. A seize normally completes in the same cycle, so two seizes can only overlap while a handover waits on the abort handshake. The stimulus holds `cmd_executing` high, lets locality 3 seize from owner 1, and then has locality 2 attempt a seize. When `abort_done` arrives, locality 3 must become the owner. Release priority is swept over all sixteen request sets of localities 0 to 3. Seize acceptance is swept over every owner and challenger pair.

// File: rtl/lty_pkg.sv
`timescale 1ns/1ps
// Shared constants for the locality ownership arbiter.
// Assumes at most eight localities (three address bits select one).
package lty_pkg;
    localparam int LOC_W    = 3;
    localparam int ACC_W    = 8;
    // access register bit positions (software decodes them)
    localparam int B_REGOK  = 7;
    localparam int B_ACT    = 5;
    localparam int B_SEIZED = 4;
    localparam int B_SEIZE  = 3;
    localparam int B_PEND   = 2;
    localparam int B_REQ    = 1;
    localparam int B_EST    = 0;
endpackage

// File: rtl/lty_bus_decode.sv
`timescale 1ns/1ps
// Address decode: splits the bus address into locality and window offset,
// selects the access register and qualifies writes. Locality NUM_LOC-1 is
// writable only by accesses flagged as hardware. Assumes NUM_LOC <= 8.
module lty_bus_decode import lty_pkg::*; #(
    parameter int NUM_LOC  = 5,
    parameter int WIN_BITS = 12,
    localparam int ADDR_W  = WIN_BITS + LOC_W
) (
    input  logic              valid,
    input  logic              write,
    input  logic              from_hw,
    input  logic [ADDR_W-1:0] addr,
    output logic [LOC_W-1:0]  loc,
    output logic              acc_sel,
    output logic              wr_en
);
    logic loc_ok;
    logic off_zero;
    logic hw_only;

    // locality field and window offset
    assign loc      = addr[WIN_BITS +: LOC_W];
    assign loc_ok   = int'(loc) < NUM_LOC;
    assign off_zero = (addr[WIN_BITS-1:0] == '0);
    assign acc_sel  = loc_ok && off_zero;
    // hardware-only locality guard
    assign hw_only  = (int'(loc) == NUM_LOC - 1);
    assign wr_en    = valid && write && acc_sel && (!hw_only || from_hw);
endmodule

// File: rtl/lty_read_mux.sv
`timescale 1ns/1ps
// Composes the access register value seen by a locality. The seize flag is
// never exposed; the pending bit is computed from the other localities'
// request flags. Non-selected addresses read zero.
module lty_read_mux import lty_pkg::*; #(
    parameter int NUM_LOC = 5
) (
    input  logic               acc_sel,
    input  logic [LOC_W-1:0]   loc,
    input  logic [NUM_LOC-1:0] ru,
    input  logic [NUM_LOC-1:0] bs,
    input  logic               act_v,
    input  logic [LOC_W-1:0]   act_id,
    input  logic               established,
    output logic [ACC_W-1:0]   rdata
);
    logic others_req;

    // any locality other than the reader requesting
    always_comb begin
        others_req = 1'b0;
        for (int l = 0; l < NUM_LOC; l++) begin
            if (LOC_W'(l) != loc && ru[l]) others_req = 1'b1;
        end
    end

    // register image
    always_comb begin
        rdata = '0;
        if (acc_sel) begin
            rdata[B_REGOK]  = 1'b1;
            rdata[B_ACT]    = act_v && (act_id == loc);
            rdata[B_SEIZED] = bs[loc];
            rdata[B_PEND]   = others_req;
            rdata[B_REQ]    = ru[loc];
            rdata[B_EST]    = !established;
        end
    end
endmodule

// File: rtl/lty_own_core.sv
`timescale 1ns/1ps
// Ownership state: per-locality request, seize and been-seized flags, the
// active owner, and the abort handshake that defers a handover while a
// command executes. Assumes wr_loc < NUM_LOC whenever wr_en is high.
module lty_own_core import lty_pkg::*; #(
    parameter int NUM_LOC = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [LOC_W-1:0]   wr_loc,
    input  logic [ACC_W-1:0]   wr_data,
    input  logic               cmd_executing,
    input  logic               abort_done,
    output logic [NUM_LOC-1:0] ru_q,
    output logic [NUM_LOC-1:0] bs_q,
    output logic               act_v_q,
    output logic [LOC_W-1:0]   act_id_q,
    output logic               cancel_req,
    output logic               chg_q,
    output logic [LOC_W-1:0]   chg_id_q
);
    logic [NUM_LOC-1:0] sz_q, n_ru, n_sz, n_bs;
    logic               pend_v_q, n_pv;
    logic [LOC_W-1:0]   pend_id_q, n_pid;
    logic               n_av;
    logic [LOC_W-1:0]   n_aid;
    logic [ACC_W-1:0]   wd;
    logic               is_owner, higher_sz, top_v;
    logic [LOC_W-1:0]   top_id;
    logic               set_new, tgt_v, start;
    logic [LOC_W-1:0]   tgt_id, st_id;
    logic               ho_go, ho_v, change, n_chg;
    logic [LOC_W-1:0]   ho_id;
    logic               unused_wbits;

    assign unused_wbits = ^{wd[7:6], wd[2], wd[0]};
    assign cancel_req   = pend_v_q;

    // next-state: write decode, handover selection and application
    always_comb begin
        n_ru = ru_q; n_sz = sz_q; n_bs = bs_q;
        n_av = act_v_q; n_aid = act_id_q;
        n_pv = pend_v_q; n_pid = pend_id_q;
        ho_go = 1'b0; ho_v = 1'b0; ho_id = '0;
        set_new = 1'b1; tgt_v = act_v_q; tgt_id = act_id_q;
        start = 1'b0; st_id = '0;
        change = 1'b0; n_chg = 1'b0;
        wd = wr_data;
        if (wd[B_SEIZE]) begin
            wd[B_REQ] = 1'b0;
            wd[B_ACT] = 1'b0;
        end
        is_owner = act_v_q && (act_id_q == wr_loc);
        higher_sz = 1'b0;
        top_v = 1'b0; top_id = '0;
        for (int l = 0; l < NUM_LOC; l++) begin
            if (LOC_W'(l) > wr_loc && sz_q[l]) higher_sz = 1'b1;
            if (ru_q[l]) begin
                top_v = 1'b1;
                top_id = LOC_W'(l);
            end
        end

        if (pend_v_q && abort_done) begin
            ho_go = 1'b1; ho_v = 1'b1; ho_id = pend_id_q; n_pv = 1'b0;
        end else if (wr_en) begin
            if (wd[B_ACT]) begin
                if (is_owner) begin
                    if (top_v) begin
                        set_new = 1'b0; start = 1'b1; st_id = top_id;
                    end else begin
                        tgt_v = 1'b0;
                    end
                end else begin
                    n_ru[wr_loc] = 1'b0;
                end
            end
            if (wd[B_SEIZED]) n_bs[wr_loc] = 1'b0;
            if (wd[B_SEIZE] && (!act_v_q || wr_loc > act_id_q) &&
                !sz_q[wr_loc] && !higher_sz) begin
                for (int l = 0; l < NUM_LOC; l++) begin
                    if (LOC_W'(l) < wr_loc) n_sz[l] = 1'b0;
                end
                n_sz[wr_loc] = 1'b1;
                set_new = 1'b0; start = 1'b1; st_id = wr_loc;
            end
            if (wd[B_REQ] && !is_owner) begin
                if (act_v_q) n_ru[wr_loc] = 1'b1;
                else begin
                    tgt_v = 1'b1; tgt_id = wr_loc;
                end
            end
            if (pend_v_q) begin
                if (start) n_pid = st_id;
            end else if (start) begin
                if (cmd_executing) begin
                    n_pv = 1'b1; n_pid = st_id;
                end else begin
                    ho_go = 1'b1; ho_v = 1'b1; ho_id = st_id;
                end
            end else if (set_new) begin
                ho_go = 1'b1; ho_v = tgt_v; ho_id = tgt_id;
            end
        end

        if (ho_go) begin
            change = (ho_v != act_v_q) || (ho_v && ho_id != act_id_q);
            if (change && act_v_q) begin
                if (ho_v && n_sz[ho_id]) n_bs[act_id_q] = 1'b1;
                else                     n_ru[act_id_q] = 1'b0;
            end
            n_av  = ho_v;
            n_aid = ho_v ? ho_id : '0;
            if (ho_v) begin
                n_ru[ho_id] = 1'b0;
                n_sz[ho_id] = 1'b0;
            end
            n_chg = change && ho_v;
        end
    end

    // state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ru_q <= '0; sz_q <= '0; bs_q <= '0;
            act_v_q <= 1'b0; act_id_q <= '0;
            pend_v_q <= 1'b0; pend_id_q <= '0;
            chg_q <= 1'b0; chg_id_q <= '0;
        end else begin
            ru_q <= n_ru; sz_q <= n_sz; bs_q <= n_bs;
            act_v_q <= n_av; act_id_q <= n_aid;
            pend_v_q <= n_pv; pend_id_q <= n_pid;
            chg_q <= n_chg; chg_id_q <= ho_id;
        end
    end

    // at most one seize can be outstanding (R6)
    p_one_seize_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sz_q) <= 1);
    // the owner never holds its own request flag (R3)
    p_owner_no_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        act_v_q |-> !ru_q[act_id_q]);
    // change pulse names the owner now in place (R8)
    p_chg_names_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
        chg_q |-> act_v_q && act_id_q == chg_id_q);
    // owner frozen while abort is outstanding (R10)
    p_hold_in_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_req && !abort_done |=> cancel_req && $stable(act_v_q) && $stable(act_id_q));
    // been-seized appears only on a locality that just lost ownership (R7)
    for (genvar g = 0; g < NUM_LOC; g++) begin : g_bs_chk
        p_seized_loser_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(bs_q[g]) |-> $past(act_v_q) && $past(act_id_q) == LOC_W'(g) &&
                               !(act_v_q && act_id_q == LOC_W'(g)));
    end
endmodule

// File: rtl/lty_owner_arb.sv
`timescale 1ns/1ps
// Top of the locality ownership arbiter: bus decode, ownership core and
// access-register read image. Reads are combinational; writes take effect
// at the next clock edge. Assumes NUM_LOC <= 8.
module lty_owner_arb import lty_pkg::*; #(
    parameter int NUM_LOC  = 5,
    parameter int WIN_BITS = 12,
    localparam int ADDR_W  = WIN_BITS + LOC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic              bus_from_hw,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [ACC_W-1:0]  bus_wdata,
    output logic [ACC_W-1:0]  bus_rdata,
    input  logic              established,
    input  logic              cmd_executing,
    input  logic              abort_done,
    output logic              cancel_req,
    output logic              owner_valid,
    output logic [LOC_W-1:0]  owner_id,
    output logic              loc_changed,
    output logic [LOC_W-1:0]  loc_changed_id
);
    logic [LOC_W-1:0]   loc;
    logic               acc_sel, wr_en;
    logic [NUM_LOC-1:0] ru, bs;

    lty_bus_decode #(.NUM_LOC(NUM_LOC), .WIN_BITS(WIN_BITS)) u_dec (
        .valid(bus_valid), .write(bus_write), .from_hw(bus_from_hw),
        .addr(bus_addr), .loc(loc), .acc_sel(acc_sel), .wr_en(wr_en));

    lty_own_core #(.NUM_LOC(NUM_LOC)) u_core (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_loc(loc),
        .wr_data(bus_wdata), .cmd_executing(cmd_executing),
        .abort_done(abort_done), .ru_q(ru), .bs_q(bs),
        .act_v_q(owner_valid), .act_id_q(owner_id), .cancel_req(cancel_req),
        .chg_q(loc_changed), .chg_id_q(loc_changed_id));

    lty_read_mux #(.NUM_LOC(NUM_LOC)) u_rd (
        .acc_sel(acc_sel), .loc(loc), .ru(ru), .bs(bs),
        .act_v(owner_valid), .act_id(owner_id),
        .established(established), .rdata(bus_rdata));
endmodule

// File: tb/sim_lty_owner_arb.sv
`timescale 1ns/1ps
module sim_lty_owner_arb;
    localparam logic [7:0] AL = 8'h20, BS = 8'h10, SZ = 8'h08, RU = 8'h02;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_valid = 1'b0, bus_write = 1'b0, bus_from_hw = 1'b0;
    logic [14:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0, bus_rdata;
    logic established = 1'b1, cmd_executing = 1'b0, abort_done = 1'b0;
    logic cancel_req, owner_valid, loc_changed;
    logic [2:0] owner_id, loc_changed_id;
    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    lty_owner_arb u0 (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_rst();
        @(negedge clk); rst_n = 1'b0; cmd_executing = 1'b0; abort_done = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic wr(input logic [2:0] loc, input logic [7:0] d, input bit hw);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_from_hw = hw;
        bus_addr = {loc, 12'h000}; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_from_hw = 1'b0;
    endtask

    task automatic rd(input logic [2:0] loc, input logic [11:0] off, output logic [7:0] v);
        bus_addr = {loc, off}; #1; v = bus_rdata;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        do_rst();
        // R1 reset state
        for (int l = 0; l < 5; l++) begin
            rd(3'(l), 12'h0, v); chk("R1 reset access", v, 8'h80);
        end
        chk("R1 no owner", owner_valid, 0);
        chk("R1 cancel low", cancel_req, 0);
        // R2 establishment bit and other offsets
        established = 1'b0; rd(0, 12'h0, v); chk("R2 est inverted", v, 8'h81);
        established = 1'b1; rd(0, 12'h004, v); chk("R2 other offset", v, 8'h00);
        // R11 out-of-range localities
        rd(6, 12'h0, v); chk("R11 loc6 read", v, 8'h00);
        wr(6, RU, 1'b0); chk("R11 loc6 write ignored", owner_valid, 0);
        // R3 grant when idle, R8 pulse
        wr(2, RU, 1'b0);
        chk("R3 idle grant", {owner_valid, owner_id}, {1'b1, 3'd2});
        chk("R8 pulse", {loc_changed, loc_changed_id}, {1'b1, 3'd2});
        rd(2, 12'h0, v); chk("R3 owner image", v, 8'hA0);
        wr(0, RU, 1'b0);
        chk("R8 no pulse without change", loc_changed, 0);
        rd(0, 12'h0, v); chk("R3 request flag set", v, 8'h82);
        rd(2, 12'h0, v); chk("R2 pending seen by owner", v, 8'hA4);
        wr(2, RU, 1'b0);
        rd(2, 12'h0, v); chk("R3 owner request ignored", v, 8'hA4);
        // R5 non-owner release clears own request only
        wr(0, AL, 1'b0);
        rd(0, 12'h0, v); chk("R5 request cleared", v, 8'h80);
        chk("R5 owner kept", {owner_valid, owner_id}, {1'b1, 3'd2});
        // R9 software write to locality 4 ignored
        do_rst();
        wr(4, RU, 1'b0);
        chk("R9 sw write ignored", owner_valid, 0);
        rd(4, 12'h0, v); chk("R9 loc4 image", v, 8'h80);
        // R4 release sweep over every request set of localities 0..3
        for (int m = 0; m < 16; m++) begin
            int top, rest;
            do_rst();
            wr(4, RU, 1'b1);
            chk("R9 hw write grants", {owner_valid, owner_id}, {1'b1, 3'd4});
            for (int b = 0; b < 4; b++) if (m[b]) wr(3'(b), RU, 1'b0);
            wr(4, AL, 1'b1);
            top = -1;
            for (int b = 0; b < 4; b++) if (m[b]) top = b;
            rest = (top < 0) ? 0 : (m & ~(1 << top));
            if (top < 0) chk("R4 release to nobody", owner_valid, 0);
            else chk("R4 highest requester", {owner_valid, owner_id}, {1'b1, 3'(top)});
            chk("R8 release pulse", loc_changed, (top >= 0));
            rd(4, 12'h0, v);
            chk("R4 old owner flags", v, 8'h80 | ((rest != 0) ? 8'h04 : 8'h00));
        end
        // R6/R7 seize sweep over owner and challenger
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 5; b++) begin
                if (b == a) continue;
                do_rst();
                wr(3'(a), RU, 1'b0);
                wr(3'(b), SZ | RU | AL, b == 4);
                if (b > a) begin
                    chk("R6 seize accepted", {owner_valid, owner_id}, {1'b1, 3'(b)});
                    rd(3'(a), 12'h0, v); chk("R7 loser seized", v, 8'h90);
                    rd(3'(b), 12'h0, v); chk("R6 winner image", v, 8'hA0);
                    wr(3'(a), BS, 1'b0);
                    rd(3'(a), 12'h0, v); chk("R7 seized cleared", v, 8'h80);
                end else begin
                    chk("R6 seize refused", {owner_valid, owner_id}, {1'b1, 3'(a)});
                    rd(3'(b), 12'h0, v); chk("R6 request bit dropped", v, 8'h80);
                end
            end
        end
        do_rst();
        wr(1, SZ, 1'b0);
        chk("R6 seize when idle", {owner_valid, owner_id}, {1'b1, 3'd1});
        // R10 abort handshake, R6 refusal behind a higher pending seize
        do_rst();
        wr(1, RU, 1'b0);
        cmd_executing = 1'b1;
        wr(3, SZ, 1'b0);
        chk("R10 cancel raised", cancel_req, 1);
        chk("R10 owner held", {owner_valid, owner_id}, {1'b1, 3'd1});
        chk("R10 no pulse yet", loc_changed, 0);
        wr(2, SZ, 1'b0);
        wr(0, RU, 1'b0);
        chk("R10 still held", {cancel_req, owner_id}, {1'b1, 3'd1});
        @(negedge clk); abort_done = 1'b1;
        @(negedge clk); abort_done = 1'b0; cmd_executing = 1'b0;
        chk("R6 higher pending wins", {owner_valid, owner_id}, {1'b1, 3'd3});
        chk("R10 cancel dropped", cancel_req, 0);
        chk("R8 pulse after abort", {loc_changed, loc_changed_id}, {1'b1, 3'd3});
        rd(1, 12'h0, v); chk("R7 loser after abort", v, 8'h94);
        rd(3, 12'h0, v); chk("R10 new owner image", v, 8'hA4);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule